// File: doc/BRIEF.md
# Coprocessor Legacy Port Decoder

This block sits on a simple ISA-style I/O bus and owns a sixteen-address window that legacy software uses to talk to a math coprocessor. A request is presented for one clock on a strobe together with a direction flag, an address and a size flag that marks a single-byte access. The block answers only the few operations that matter for compatibility. A write to the first port clears the coprocessor busy latch. A write to the second port also clears the latch and sends a one-cycle reset pulse to the coprocessor. Every other access in the window is reported on an unsupported-access output.

The block also produces the coprocessor interrupt request. The busy latch is set from a busy input. While the latch is set, a rising edge on the coprocessor error input raises the interrupt. Every accepted byte write in the window lowers the interrupt again, whichever port it hits. All results are registered and appear one clock after the request. Write data carries no meaning for any port, so the bus data lines are not brought into the block.

Top module: `coproPortDecode`

## Requirements
- R1: The window covers addresses 0x00F0 to 0x00FF. A request with any other address, or with the strobe low, changes no output state: unsupErr stays 0, copReset stays 0, rdData stays 0x00, and busyOut and irqOut keep their values.
- R2: A request in the window with reqByte=0 (wider than one byte) pulses unsupErr for one cycle. It has no other effect: busyOut, irqOut, copReset and rdData stay unchanged or zero.
- R3: A byte write to 0x00F0 clears busyOut in the next cycle.
- R4: A byte write to 0x00F1 drives copReset high for exactly the next cycle and clears busyOut in that same cycle.
- R5: busyIn=1 sets busyOut in the next cycle, and busyOut holds until it is cleared. When a clear from R3 or R4 and busyIn=1 arrive in the same cycle, the clear wins.
- R6: When busyOut is 1 and errIn rises (1 now, 0 in the previous cycle), irqOut goes high in the next cycle and stays high. Holding errIn high does not raise irqOut again, and an edge while busyOut is 0 has no effect.
- R7: Every byte write anywhere in the window drives irqOut low in the next cycle. This drop wins over a set from R6 in the same cycle.
- R8: A byte write to 0x00F2 through 0x00FF (including the opcode ports 0x00F8, 0x00FA and 0x00FC) pulses unsupErr for one cycle, drops irqOut as in R7, and leaves busyOut unchanged.
- R9: A byte read anywhere in the window returns rdData=0xFF for one cycle and pulses unsupErr. irqOut and busyOut are not changed. In every other cycle rdData is 0x00.
- R10: A synchronous reset (rst=1 at a clock edge) clears busyOut, irqOut, unsupErr, copReset and rdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | One-cycle request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | 1 = single-byte access, 0 = wider access |
| reqAddr | input | ADDR_W (16) | I/O address |
| busyIn | input | 1 | Coprocessor busy indication; sets the latch |
| errIn | input | 1 | Coprocessor error indication; rising edge raises the interrupt while busy |
| busyOut | output | 1 | Busy latch state |
| irqOut | output | 1 | Coprocessor interrupt request |
| copReset | output | 1 | One-cycle coprocessor reset pulse |
| unsupErr | output | 1 | One-cycle unsupported-access flag |
| rdData | output | DATA_W (8) | Read data: all ones the cycle after a byte read in the window |

## Verification
Every result of this block comes from a single register stage, so each output is due exactly one clock after the edge that samples the request, busyIn or errIn. The bench applies each stimulus at the falling edge and advances its reference model at the next rising edge. It compares all five outputs two time units after that edge, so copReset, unsupErr and rdData are seen in the only cycle they are valid. Chained cases, such as the cycle after a reset pulse or an error edge held for several cycles, are checked as separate steps, each with its own one-cycle expectation.

// File: rtl/coproPortPkg.sv
package coproPortPkg;

  // Port offsets inside the window; behaviour depends on these two.
  localparam logic [3:0] OFS_CLEAR = 4'h0;
  localparam logic [3:0] OFS_RESET = 4'h1;

  // Strobes from control to datapath, valid for the cycle of a request.
  typedef struct packed {
    logic clrBusy;
    logic pulseReset;
    logic dropIrq;
    logic flagErr;
    logic readOnes;
  } coproStrobes_t;

endpackage

// File: rtl/coproPortCtrl.sv
module coproPortCtrl
  import coproPortPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 'h00F0
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [ADDR_W-1:0] reqAddr,
  output coproStrobes_t     stb
);
  localparam int PAGE_W = ADDR_W - 4;
  localparam logic [PAGE_W-1:0] BASE_PAGE = BASE[ADDR_W-1:4];

  logic       inWindow;
  logic [3:0] offset;
  logic       byteWrite;
  logic       byteRead;
  logic       knownPort;

  always_comb begin
    inWindow  = reqValid && (reqAddr[ADDR_W-1:4] == BASE_PAGE);
    offset    = reqAddr[3:0];
    byteWrite = inWindow && reqByte && reqWrite;
    byteRead  = inWindow && reqByte && !reqWrite;
    knownPort = (offset == OFS_CLEAR) || (offset == OFS_RESET);

    stb.clrBusy    = byteWrite && knownPort;
    stb.pulseReset = byteWrite && (offset == OFS_RESET);
    stb.dropIrq    = byteWrite;
    stb.readOnes   = byteRead;
    stb.flagErr    = inWindow && (!reqByte || !reqWrite || !knownPort);
  end

endmodule

// File: rtl/coproPortDatapath.sv
module coproPortDatapath
  import coproPortPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  coproStrobes_t     stb,
  input  logic              busyIn,
  input  logic              errIn,
  output logic              busyOut,
  output logic              irqOut,
  output logic              copReset,
  output logic              unsupErr,
  output logic [DATA_W-1:0] rdData
);
  logic busyQ, busyD;
  logic irqQ, irqD;
  logic errPrev;
  logic errRise;
  logic [DATA_W-1:0] rdD;

  always_comb begin
    errRise = errIn && !errPrev;

    busyD = busyQ;
    if (stb.clrBusy)   busyD = 1'b0;
    else if (busyIn)   busyD = 1'b1;

    irqD = irqQ;
    if (stb.dropIrq)              irqD = 1'b0;
    else if (busyQ && errRise)    irqD = 1'b1;

    rdD = stb.readOnes ? {DATA_W{1'b1}} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ    <= 1'b0;
      irqQ     <= 1'b0;
      errPrev  <= 1'b0;
      copReset <= 1'b0;
      unsupErr <= 1'b0;
      rdData   <= '0;
    end else begin
      busyQ    <= busyD;
      irqQ     <= irqD;
      errPrev  <= errIn;
      copReset <= stb.pulseReset;
      unsupErr <= stb.flagErr;
      rdData   <= rdD;
    end
  end

  assign busyOut = busyQ;
  assign irqOut  = irqQ;

endmodule

// File: rtl/coproPortDecode.sv
module coproPortDecode
  import coproPortPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 'h00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              busyIn,
  input  logic              errIn,
  output logic              busyOut,
  output logic              irqOut,
  output logic              copReset,
  output logic              unsupErr,
  output logic [DATA_W-1:0] rdData
);
  coproStrobes_t stb;

  coproPortCtrl #(.ADDR_W(ADDR_W), .BASE(BASE)) ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqByte  (reqByte),
    .reqAddr  (reqAddr),
    .stb      (stb)
  );

  coproPortDatapath #(.DATA_W(DATA_W)) dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .busyIn   (busyIn),
    .errIn    (errIn),
    .busyOut  (busyOut),
    .irqOut   (irqOut),
    .copReset (copReset),
    .unsupErr (unsupErr),
    .rdData   (rdData)
  );

endmodule

// File: rtl/coproPortDecodeChk.sv
module coproPortDecodeChk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 'h00F0
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqByte,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              busyIn,
  input logic              errIn,
  input logic              busyOut,
  input logic              irqOut,
  input logic              copReset,
  input logic              unsupErr,
  input logic [DATA_W-1:0] rdData
);
  logic inWin;
  assign inWin = reqValid && (reqAddr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !inWin |=> (!unsupErr && !copReset && rdData == '0)); // R1

  AST_WIDE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (inWin && !reqByte) |=> (unsupErr && !copReset && rdData == '0)); // R2

  AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (rst)
    (inWin && reqByte && reqWrite && reqAddr[3:0] == 4'h0) |=> !busyOut); // R3

  AST_RESET_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
    copReset |-> $past(inWin && reqByte && reqWrite && reqAddr[3:0] == 4'h1)); // R4

  AST_IRQ_RISE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(irqOut) |-> $past(busyOut)); // R6

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (inWin && reqByte && reqWrite) |=> !irqOut); // R7

  AST_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (inWin && reqByte && !reqWrite) |=> (rdData == {DATA_W{1'b1}} && unsupErr)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!busyOut && !irqOut && !unsupErr && !copReset)); // R10

endmodule

bind coproPortDecode coproPortDecodeChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqByte(reqByte),
  .reqAddr(reqAddr), .busyIn(busyIn), .errIn(errIn), .busyOut(busyOut), .irqOut(irqOut),
  .copReset(copReset), .unsupErr(unsupErr), .rdData(rdData)
);

// File: tb/coproPortDecode_test.sv
module coproPortDecode_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqByte = 1'b0;
  logic [15:0] reqAddr = 16'h0;
  logic        busyIn = 1'b0, errIn = 1'b0;
  logic        busyOut, irqOut, copReset, unsupErr;
  logic [7:0]  rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic mBusy = 0, mIrq = 0, mErrPrev = 0, mRst = 0, mUns = 0;
  logic [7:0] mRd = 0;

  always #5 clk = ~clk;

  coproPortDecode uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqByte(reqByte),
    .reqAddr(reqAddr), .busyIn(busyIn), .errIn(errIn), .busyOut(busyOut), .irqOut(irqOut),
    .copReset(copReset), .unsupErr(unsupErr), .rdData(rdData)
  );

  function automatic bit inWindow(input logic v, input logic [15:0] a);
    return v && (a >= 16'h00F0) && (a <= 16'h00FF);
  endfunction

  task automatic cmp(input string tag, input string name, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", tag, name, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic w, input logic b,
                      input logic [15:0] a, input logic bi, input logic ei, input logic r);
    bit win, acc, known;
    rst = r; reqValid = v; reqWrite = w; reqByte = b; reqAddr = a; busyIn = bi; errIn = ei;
    @(posedge clk);
    win   = inWindow(v, a);
    acc   = win && b && w;
    known = (a == 16'h00F0) || (a == 16'h00F1);
    if (r) begin
      mBusy = 0; mIrq = 0; mErrPrev = 0; mRst = 0; mUns = 0; mRd = 0;
    end else begin
      if (acc) mIrq = 0;
      else if (mBusy && ei && !mErrPrev) mIrq = 1;
      if (acc && known) mBusy = 0;
      else if (bi) mBusy = 1;
      mErrPrev = ei;
      mRst = acc && (a == 16'h00F1);
      mUns = win && (!b || !w || !known);
      mRd  = (win && b && !w) ? 8'hFF : 8'h00;
    end
    #2;
    cmp(tag, "busyOut R5",  {7'b0, busyOut},  {7'b0, mBusy});
    cmp(tag, "irqOut R6",   {7'b0, irqOut},   {7'b0, mIrq});
    cmp(tag, "copReset R4", {7'b0, copReset}, {7'b0, mRst});
    cmp(tag, "unsupErr R8", {7'b0, unsupErr}, {7'b0, mUns});
    cmp(tag, "rdData R9",   rdData,           mRd);
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input logic bi, input logic ei);
    step(tag, 0, 0, 1, 16'h0000, bi, ei, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got running expected finished");
    finishRun();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_C0DE);
    @(negedge clk);
    step("R10 reset", 0, 0, 0, 16'h0, 1, 1, 1);
    step("R10 reset", 0, 0, 0, 16'h0, 0, 0, 1);

    idle("R5 set busy", 1, 0);
    idle("R5 hold busy", 0, 0);
    step("R3 clear F0", 1, 1, 1, 16'h00F0, 0, 0, 0);
    step("R5 clear beats set", 1, 1, 1, 16'h00F0, 1, 0, 0);
    idle("R5 set again", 1, 0);
    idle("R6 err rise", 0, 1);
    idle("R6 err held", 0, 1);
    idle("R6 err held", 0, 1);
    step("R8 opcode F8", 1, 1, 1, 16'h00F8, 0, 1, 0);
    idle("R6 no re-raise", 0, 1);
    idle("R6 err low", 0, 0);
    step("R7 drop beats set", 1, 1, 1, 16'h00FA, 0, 1, 0);
    idle("R7 err low", 0, 0);
    idle("R6 raise", 0, 1);
    step("R2 wide write F0", 1, 1, 0, 16'h00F0, 0, 0, 0);
    step("R9 byte read F5", 1, 0, 1, 16'h00F5, 0, 0, 0);
    step("R2 wide read", 1, 0, 0, 16'h00FC, 0, 0, 0);
    step("R1 outside 0092", 1, 1, 1, 16'h0092, 0, 0, 0);
    step("R1 outside 01F0", 1, 0, 1, 16'h01F0, 0, 0, 0);
    step("R4 reset F1", 1, 1, 1, 16'h00F1, 0, 0, 0);
    idle("R4 pulse ends", 0, 0);
    idle("R6 idle busy", 0, 1);
    step("R8 opcode FC", 1, 1, 1, 16'h00FC, 0, 0, 0);
    step("R8 top FF", 1, 1, 1, 16'h00FF, 1, 0, 0);
    step("R10 mid reset", 0, 0, 0, 16'h0, 1, 1, 1);
    idle("R10 after", 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic v, w, b, bi, ei, r;
      logic [15:0] a;
      v  = ($urandom % 4) != 0;
      w  = $urandom % 2;
      b  = ($urandom % 8) != 0;
      a  = (($urandom % 8) < 6) ? (16'h00F0 + 16'($urandom % 16)) : 16'($urandom);
      bi = ($urandom % 5) == 0;
      ei = ($urandom % 3) == 0;
      r  = ($urandom % 60) == 0;
      step("R1 random", v, w, b, a, bi, ei, r);
    end
    finishRun();
  end

endmodule